// File: doc/BRIEF.md
# Pipelined-Free Synchronous Burst SRAM

This block models a flow-through synchronous static memory that needs no idle cycle when the bus turns from read to write or back. Each word is 18 bits, split into two 9-bit byte lanes. On a rising clock edge the block samples every control input, but only while the active-low clock enable is low. With the clock enable high, the edge is ignored and the current access is held. Three chip enables decide whether the memory is selected. A single advance/load input either starts a new access or steps a 2-bit burst counter. A strap input picks a linear or an interleaved burst order.

A read address registered on an edge drives its word onto the output in the cycle that follows, with no output register in between. A write address registered on an edge takes its data and lane strobes from the next enabled edge. Because of this, reads and writes can alternate on consecutive cycles. The data bus is split into an input port, an output port and an output-enable flag. The flag follows the asynchronous active-low output enable, except during a write data phase, while the memory is deselected, and in the first cycle after it leaves deselect. In those cycles the flag is forced low.

Top module: `sburst_sram`

## Requirements
- R1: While reset is asserted, and after reset until the first selected load, the memory is deselected and `dout_en` is 0.
- R2: An edge with `clk_en_n` high changes nothing: the access address, the selection and the operation are held, and no write data is committed. A load that would deselect is also ignored during a stall.
- R3: A load (`adv_ld` = 0) selects the memory only when `sel1_n` = 0, `sel2` = 1 and `sel3_n` = 0. Any other combination deselects it.
- R4: A selected load takes the address and the operation (`wr_n` = 0 means write) from the inputs. During a burst, the address bits above the low two stay at their loaded value, and the address inputs are ignored.
- R5: An advance (`adv_ld` = 1) while the memory is selected steps the burst counter. An advance while it is deselected has no effect.
- R6: With `burst_mode` = 0, the low two address bits of beat k are (start + k) mod 4.
- R7: With `burst_mode` = 1, the low two address bits of beat k are start XOR k.
- R8: Write data is taken at the first enabled edge after the write address is registered. `lane_wr_n` is active low. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. A lane whose strobe is high keeps its old content.
- R9: In the cycle after a read address is registered, `dout` shows the word stored at that address.
- R10: `dout_en` equals `!oe_n` (without waiting for a clock) during a read. It is forced to 0 during a write data phase, while deselected, and in the first cycle after a selected load made from the deselected state.
- R11: A write may directly follow a read, and a read may directly follow a write. A read of the address just written returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load a new access, 1 = advance the burst |
| wr_n | input | 1 | Operation on load, 0 = write, 1 = read |
| lane_wr_n | input | 2 | Byte-lane write strobes, active low |
| addr | input | 6 | Word address |
| burst_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | 18 | Write data |
| dout | output | 18 | Read data |
| dout_en | output | 1 | High when the block should drive the data bus |

## Verification
The array is first filled with back-to-back writes and then read back with back-to-back single reads. After that, burst reads are run from every start address in both orders, so that linear and interleaved stepping are told apart at each start offset. The bench also sweeps all eight enable combinations, with one advance after each, to separate selection from deselection and to show that an advance while deselected has no effect. Further cases cover stalls in the middle of a burst and in the middle of a write, partial lane writes, an interleaved write burst, and read/write turnarounds at a single address. Together these separate the write data phase, the first cycle out of deselect and the asynchronous output enable.

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_mode,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              active, op_wr, fresh;
  logic [ADDR_W-3:0] base_hi;
  logic [1:0]        start, cnt, offset;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_word;

  wire fire     = !clk_en_n;
  wire selected = !sel1_n && sel2 && !sel3_n;
  wire commit   = fire && active && op_wr;

  assign offset   = burst_mode ? (start ^ cnt) : (start + cnt);
  assign cur_addr = {base_hi, offset};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      op_wr   <= 1'b0;
      fresh   <= 1'b0;
      base_hi <= '0;
      start   <= '0;
      cnt     <= '0;
    end else if (fire) begin
      if (!adv_ld) begin
        active <= selected;
        fresh  <= selected && !active;
        if (selected) begin
          base_hi <= addr[ADDR_W-1:2];
          start   <= addr[1:0];
          cnt     <= 2'd0;
          op_wr   <= !wr_n;
        end
      end else begin
        fresh <= 1'b0;
        if (active) cnt <= cnt + 2'd1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (commit && !lane_wr_n[g]) cells[cur_addr] <= din[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = cells[cur_addr];
  end

  assign dout    = rd_word;
  assign dout_en = active && !op_wr && !fresh && !oe_n;

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(cur_addr) && $stable(active) && $stable(op_wr));

  p_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && (sel1_n || !sel2 || sel3_n)) |=> !active);

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && active) |=> $stable(base_hi) && $stable(op_wr));

  p_idle_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && !active) |=> !active && !dout_en);

  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && active && !burst_mode) |=>
      (burst_mode || offset == 2'($past(offset) + 2'd1)));

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op_wr) |-> !dout_en);

  p_fresh_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && selected && !active) |=> !dout_en);
endmodule

// File: tb/sburst_sram_bench.sv
`timescale 1ns/1ps
module sburst_sram_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic adv_ld = 1'b1, wr_n = 1'b1, burst_mode = 1'b0, oe_n = 1'b0;
  logic [1:0]  lane_wr_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_en;
  logic [17:0] exp_mem [64];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sburst_sram u_sburst_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .adv_ld(adv_ld), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .burst_mode(burst_mode), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en));

  function automatic logic [17:0] pat(int a, int salt);
    return 18'((a * 1237 + salt * 4099 + 91) & 18'h3FFFF);
  endfunction

  task automatic chk_v(string req, logic [17:0] act, logic [17:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic chk_b(string req, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load(bit wr, logic [5:0] a, logic [17:0] d);
    clk_en_n = 0; adv_ld = 0; sel1_n = 0; sel2 = 1; sel3_n = 0;
    wr_n = !wr; addr = a; din = d;
  endtask

  task automatic adv(logic [17:0] d);
    clk_en_n = 0; adv_ld = 1; din = d; addr = ~addr;
  endtask

  task automatic desel(logic [17:0] d);
    clk_en_n = 0; adv_ld = 0; sel1_n = 1; sel2 = 1; sel3_n = 0; din = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [17:0] v;
    logic [5:0] a;
    tick(); tick();
    chk_b("R1 reset", dout_en, 1'b0);
    rst_n = 1; adv(0); tick();
    chk_b("R1 idle after reset", dout_en, 1'b0);

    // R8 R11 fill with back-to-back writes
    for (int i = 0; i < 64; i++) begin
      lane_wr_n = 2'b00;
      load(1, 6'(i), i == 0 ? 18'h0 : pat(i - 1, 0));
      tick();
      if (i > 0) exp_mem[i-1] = pat(i - 1, 0);
      if (i % 16 == 5) chk_b("R10 write phase", dout_en, 1'b0);
    end
    desel(pat(63, 0)); tick();
    exp_mem[63] = pat(63, 0);
    chk_b("R3 deselected", dout_en, 1'b0);

    load(0, 0, 0); tick();
    chk_b("R10 first cycle out of deselect", dout_en, 1'b0);
    for (int i = 0; i < 64; i++) begin
      load(0, 6'(i), 0); tick();
      chk_v("R9 read", dout, exp_mem[i]);
      chk_b("R9 read enable", dout_en, 1'b1);
    end

    // R6 R7 R4 bursts from every start
    for (int m = 0; m < 2; m++) begin
      burst_mode = m[0];
      for (int s = 0; s < 64; s++) begin
        load(0, 6'(s), 0); tick();
        for (int b = 0; b < 4; b++) begin
          if (b > 0) begin adv(0); tick(); end
          a = {6'(s) >> 2, (m == 1) ? (2'(s) ^ 2'(b)) : 2'(s + b)} ;
          a = {6'(s) & 6'h3C} | {4'b0, (m == 1) ? (2'(s) ^ 2'(b)) : 2'(s + b)};
          chk_v(m == 1 ? "R7 interleaved beat" : "R6 linear beat", dout, exp_mem[a]);
        end
      end
    end
    burst_mode = 0;

    // R2 stall mid burst
    load(0, 8, 0); tick();
    adv(0); tick();
    clk_en_n = 1; adv_ld = 0; sel1_n = 1; addr = 40;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_v("R2 stall hold data", dout, exp_mem[9]);
      chk_b("R2 stall keeps selection", dout_en, 1'b1);
    end
    adv(0); sel1_n = 0; tick();
    chk_v("R2 burst resumes", dout, exp_mem[10]);

    // R2 stall during write data phase
    lane_wr_n = 2'b00;
    load(1, 50, 0); tick();
    clk_en_n = 1; din = 18'h15555; tick();
    v = 18'h2AAAA;
    load(0, 50, v); tick();
    exp_mem[50] = v;
    chk_v("R2 R11 stall write commit", dout, v);

    // R3 R5 decode sweep
    for (int c = 0; c < 8; c++) begin
      bit ok;
      ok = (c == 3'b010);
      load(0, 31, 0); tick();
      load(0, 30, 0); tick();
      load(0, 32, 0); sel1_n = c[0]; sel2 = c[1]; sel3_n = c[2]; tick();
      chk_b("R3 decode", dout_en, ok);
      if (ok) chk_v("R3 decode data", dout, exp_mem[32]);
      adv(0); tick();
      chk_b("R5 advance after decode", dout_en, ok);
      if (!ok) begin
        load(0, 33, 0); tick();
        chk_b("R10 fresh after deselect", dout_en, 1'b0);
        adv(0); tick();
        chk_b("R5 advance active", dout_en, 1'b1);
        chk_v("R5 advance data", dout, exp_mem[34]);
      end
    end

    // R10 asynchronous output enable
    load(0, 5, 0); tick();
    oe_n = 1; #1;
    chk_b("R10 oe off", dout_en, 1'b0);
    oe_n = 0; #1;
    chk_b("R10 oe on", dout_en, 1'b1);
    chk_v("R10 oe data", dout, exp_mem[5]);

    // R8 lane strobes
    load(1, 10, 0); lane_wr_n = 2'b11; tick();
    load(1, 11, 18'h3FFFF); lane_wr_n = 2'b01; tick();
    exp_mem[10] = {9'h1FF, exp_mem[10][8:0]};
    load(1, 12, 18'h3FFFF); lane_wr_n = 2'b10; tick();
    exp_mem[11] = {exp_mem[11][17:9], 9'h1FF};
    load(0, 10, 18'h3FFFF); lane_wr_n = 2'b11; tick();
    chk_v("R8 upper lane only", dout, exp_mem[10]);
    load(0, 11, 0); tick();
    chk_v("R8 lower lane only", dout, exp_mem[11]);
    load(0, 12, 0); tick();
    chk_v("R8 no lane", dout, exp_mem[12]);

    // R7 R11 interleaved write burst from start 2
    burst_mode = 1; lane_wr_n = 2'b00;
    load(1, 22, 0); tick();
    for (int b = 1; b < 4; b++) begin
      adv(pat(b, 7)); tick();
      exp_mem[6'd20 | 6'(2 ^ (b - 1))] = pat(b, 7);
    end
    load(0, 22, pat(4, 7)); tick();
    exp_mem[21] = pat(4, 7);
    for (int b = 0; b < 4; b++) begin
      if (b > 0) begin adv(0); tick(); end
      chk_v("R7 R11 write burst readback", dout, exp_mem[6'd20 | 6'(2 ^ b)]);
    end
    burst_mode = 0;

    // R11 turnarounds
    load(0, 40, 0); tick();
    chk_v("R11 read before write", dout, exp_mem[40]);
    load(1, 40, 0); tick();
    chk_b("R10 R11 write phase quiet", dout_en, 1'b0);
    v = 18'h0BEEF;
    load(0, 40, v); tick();
    exp_mem[40] = v;
    chk_v("R11 read after write", dout, v);
    chk_b("R11 read enable", dout_en, 1'b1);

    desel(0); tick();
    finish_run();
  end
endmodule